// File: doc/BRIEF.md
# In-Order Commit Tracking Buffer

This block tracks instructions from issue to retirement. Each instruction takes one slot in a circular buffer. The issue side asks to place between one and four instructions per cycle. The request is granted whole or not at all. Each granted slot receives an index: the current tail index plus the slot position, modulo the depth.

The execution side reports finished instructions by index, each with an error flag, on one or more completion ports. The block then retires finished, error-free entries strictly from the oldest one forward, up to four per cycle. Their slots become free only in the cycle after retirement.

When the oldest entry has finished with an error, retirement stops at that entry. A one-cycle exception pulse gives the entry's index. The surrounding control answers with a flush, which empties the buffer.

Two instruction classes serialize the machine and are enforced by refusing issue requests:
- A serializing instruction enters only alone, into an empty buffer, and holds off all issue until it retires.
- A blocking instruction must be the last one of its group, and holds off further issue until it retires.

Top module: `inorder_commit_buf`

## Requirements
- R1: After reset the occupancy is 0, the retire count is 0, no exception is signalled, the issue index is 0, and a request for four plain instructions is granted.
- R2: A granted group of n instructions (1 to 4) takes indices tail..tail+n-1 modulo 64. The occupancy rises by n in the next cycle.
- R3: A request for more instructions than there are free slots is refused as a whole. The occupancy is left unchanged. Slots freed by retirement count as free only from the cycle after retirement.
- R4: Retirement is combinational from the registered entry state. In each cycle, cmt_cnt counts consecutive entries, starting at cmt_head, that are occupied, finished and error-free, up to a maximum of 4. A completion reported in cycle t can first show in cmt_cnt in cycle t+1.
- R5: A finished younger entry never retires before every older entry has retired.
- R6: When the oldest entry has finished with its error flag set, cmt_cnt stays 0. exc_vld is high for exactly one cycle, with exc_idx set to that entry's index.
- R7: flush empties the buffer, clears any pending exception, and restarts both pointers at index 0. During a flush cycle, issue is refused.
- R8: Kind code 2'b01 marks a serializing instruction. It is granted only as the sole instruction (count 1) into an empty buffer. Until it retires, every issue request is refused.
- R9: Kind code 2'b10 marks a blocking instruction. It is granted only in the last requested slot of its group. Until it retires, every issue request is refused.
- R10: The pointers wrap modulo 64. The buffer holds 64 entries, and any request made while it is full is refused. Groups and retirement runs may cross the wrap point.
- R11: Kind code 2'b11 is refused. A completion naming an unoccupied index has no effect: an instruction later placed at that index does not retire until it is completed itself.
- R12: In a cycle that both grants n instructions and retires c entries, the occupancy changes by n - c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_cnt | input | 3 | Number of instructions requested this cycle (0 means no request) |
| iss_kind | input | 8 | Two-bit kind per slot; slot k uses bits 2k+1:2k (00 plain, 01 serializing, 10 blocking, 11 illegal) |
| iss_ready | output | 1 | The request is granted in this cycle |
| iss_tail | output | 6 | Index given to slot 0 of a granted group |
| cpl_vld | input | 2 | Completion valid, one bit per completion port |
| cpl_idx | input | 12 | Completed entry index, 6 bits per port |
| cpl_err | input | 2 | Completion carries an error, one bit per port |
| flush | input | 1 | Empty the buffer and restart the pointers |
| cmt_cnt | output | 3 | Number of entries retiring in this cycle |
| cmt_head | output | 6 | Index of the oldest entry |
| exc_vld | output | 1 | One-cycle pulse: the oldest entry finished with an error |
| exc_idx | output | 6 | Index of the faulting entry |
| occ | output | 7 | Number of occupied entries (0 to 64) |

## Verification
The risky overlap is a cycle in which a new group is granted while a run of four entries retires. The bench arranges this by marking several younger entries finished, then releasing the oldest one last. In the cycle where the full retire run appears, it issues two new instructions. The test is judged by the granted index, and by an occupancy that must equal the old value plus two minus four.

A second overlap places a flush in the same cycle as an issue request. Here the grant must be low, and the buffer must come back empty with its pointers at index zero.

// File: rtl/icb_pkg.sv
package icb_pkg;

   typedef enum logic [1:0] {
      KIND_PLAIN = 2'b00,
      KIND_SYNC  = 2'b01,
      KIND_STALL = 2'b10,
      KIND_BAD   = 2'b11
   } icb_kind_e;

endpackage

// File: rtl/icb_issue_gate.sv
module icb_issue_gate
   import icb_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int ISSUE_W = 4,
   localparam int NW     = $clog2(ISSUE_W + 1),
   localparam int OW     = $clog2(DEPTH + 1)
) (
   input  logic [NW-1:0]          req_cnt,
   input  logic [2*ISSUE_W-1:0]   req_kind,
   input  logic [OW-1:0]          occ,
   input  logic                   blocked,
   input  logic                   flush,
   output logic                   grant,
   output logic                   grant_blk
);

   logic bad;
   logic has_blk;

   always_comb begin : rules
      icb_kind_e kd;
      bad     = 1'b0;
      has_blk = 1'b0;
      for (int k = 0; k < ISSUE_W; k++) begin
         kd = icb_kind_e'(req_kind[2*k +: 2]);
         if (k < int'(req_cnt)) begin
            case (kd)
               KIND_SYNC: begin
                  has_blk = 1'b1;
                  if (int'(req_cnt) != 1 || occ != '0) bad = 1'b1;
               end
               KIND_STALL: begin
                  has_blk = 1'b1;
                  if (k != int'(req_cnt) - 1) bad = 1'b1;
               end
               KIND_BAD: bad = 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign grant = (req_cnt != '0) && (int'(req_cnt) <= ISSUE_W) &&
                  (int'(req_cnt) <= DEPTH - int'(occ)) &&
                  !blocked && !flush && !bad;
   assign grant_blk = has_blk;

endmodule

// File: rtl/icb_entry_array.sv
module icb_entry_array #(
   parameter int DEPTH     = 64,
   parameter int ISSUE_W   = 4,
   parameter int COMMIT_W  = 4,
   parameter int CPL_PORTS = 2,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int NW       = $clog2(ISSUE_W + 1),
   localparam int CW       = $clog2(COMMIT_W + 1),
   localparam int SW       = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        alloc_en,
   input  logic [IDX_W-1:0]            alloc_base,
   input  logic [NW-1:0]               alloc_cnt,
   input  logic [2*ISSUE_W-1:0]        alloc_kind,
   input  logic [CPL_PORTS-1:0]        cpl_vld,
   input  logic [CPL_PORTS*IDX_W-1:0]  cpl_idx,
   input  logic [CPL_PORTS-1:0]        cpl_err,
   input  logic [IDX_W-1:0]            ret_base,
   input  logic [CW-1:0]               ret_cnt,
   output logic [DEPTH-1:0]            ent_vld,
   output logic [DEPTH-1:0]            ent_done,
   output logic [DEPTH-1:0]            ent_err,
   output logic [2*DEPTH-1:0]          ent_kind
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [IDX_W-1:0] a_off;
      logic [IDX_W-1:0] r_off;
      logic             a_hit;
      logic             r_hit;
      logic             c_hit;
      logic             c_err;
      logic [1:0]       a_kind;
      logic             vld_q, done_q, err_q;
      logic [1:0]       kind_q;

      assign a_off = IDX_W'(i) - alloc_base;
      assign r_off = IDX_W'(i) - ret_base;
      assign a_hit = alloc_en && (int'(a_off) < int'(alloc_cnt));
      assign r_hit = int'(r_off) < int'(ret_cnt);

      if (ISSUE_W == 1) begin : g_one
         assign a_kind = alloc_kind[1:0];
      end else begin : g_many
         assign a_kind = alloc_kind[{a_off[SW-1:0], 1'b0} +: 2];
      end

      always_comb begin
         c_hit = 1'b0;
         c_err = 1'b0;
         for (int p = 0; p < CPL_PORTS; p++) begin
            if (cpl_vld[p] && cpl_idx[p*IDX_W +: IDX_W] == IDX_W'(i)) begin
               c_hit = 1'b1;
               c_err = c_err | cpl_err[p];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            kind_q <= 2'b00;
         end else if (flush) begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end else if (a_hit) begin
            vld_q  <= 1'b1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            kind_q <= a_kind;
         end else if (vld_q && r_hit) begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
         end else if (vld_q && c_hit) begin
            done_q <= 1'b1;
            err_q  <= c_err;
         end
      end

      assign ent_vld[i]          = vld_q;
      assign ent_done[i]         = done_q;
      assign ent_err[i]          = err_q;
      assign ent_kind[2*i +: 2]  = kind_q;
   end

endmodule

// File: rtl/icb_commit_scan.sv
module icb_commit_scan #(
   parameter int DEPTH    = 64,
   parameter int COMMIT_W = 4,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CW      = $clog2(COMMIT_W + 1)
) (
   input  logic [DEPTH-1:0]    ent_vld,
   input  logic [DEPTH-1:0]    ent_done,
   input  logic [DEPTH-1:0]    ent_err,
   input  logic [2*DEPTH-1:0]  ent_kind,
   input  logic [IDX_W-1:0]    head,
   output logic [CW-1:0]       ret_cnt,
   output logic                ret_special,
   output logic                head_fault
);

   always_comb begin : scan
      logic             run;
      logic [IDX_W-1:0] p;
      ret_cnt     = '0;
      ret_special = 1'b0;
      run         = 1'b1;
      for (int k = 0; k < COMMIT_W; k++) begin
         p = head + IDX_W'(k);
         if (run && ent_vld[p] && ent_done[p] && !ent_err[p]) begin
            ret_cnt = ret_cnt + CW'(1);
            if (ent_kind[{p, 1'b0} +: 2] != 2'b00) ret_special = 1'b1;
         end else begin
            run = 1'b0;
         end
      end
   end

   assign head_fault = ent_vld[head] && ent_done[head] && ent_err[head];

endmodule

// File: rtl/inorder_commit_buf.sv
module inorder_commit_buf #(
   parameter int DEPTH     = 64,
   parameter int ISSUE_W   = 4,
   parameter int COMMIT_W  = 4,
   parameter int CPL_PORTS = 2,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int NW       = $clog2(ISSUE_W + 1),
   localparam int CW       = $clog2(COMMIT_W + 1),
   localparam int OW       = $clog2(DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NW-1:0]               iss_cnt,
   input  logic [2*ISSUE_W-1:0]        iss_kind,
   output logic                        iss_ready,
   output logic [IDX_W-1:0]            iss_tail,
   input  logic [CPL_PORTS-1:0]        cpl_vld,
   input  logic [CPL_PORTS*IDX_W-1:0]  cpl_idx,
   input  logic [CPL_PORTS-1:0]        cpl_err,
   input  logic                        flush,
   output logic [CW-1:0]               cmt_cnt,
   output logic [IDX_W-1:0]            cmt_head,
   output logic                        exc_vld,
   output logic [IDX_W-1:0]            exc_idx,
   output logic [OW-1:0]               occ
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ISSUE_W < 1 || ISSUE_W >= DEPTH) begin : g_chk_issue
      $error("ISSUE_W must lie in 1..DEPTH-1");
   end
   if (COMMIT_W < 1 || COMMIT_W >= DEPTH) begin : g_chk_commit
      $error("COMMIT_W must lie in 1..DEPTH-1");
   end
   if (CPL_PORTS < 1) begin : g_chk_cpl
      $error("CPL_PORTS must be at least 1");
   end

   logic [IDX_W-1:0]   head_q, tail_q;
   logic [OW-1:0]      occ_q;
   logic               blk_q, seen_q;
   logic               grant, grant_blk;
   logic [CW-1:0]      ret_cnt;
   logic               ret_special, head_fault;
   logic [DEPTH-1:0]   ent_vld, ent_done, ent_err;
   logic [2*DEPTH-1:0] ent_kind;

   icb_issue_gate #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_gate (
      .req_cnt   (iss_cnt),
      .req_kind  (iss_kind),
      .occ       (occ_q),
      .blocked   (blk_q),
      .flush     (flush),
      .grant     (grant),
      .grant_blk (grant_blk)
   );

   icb_entry_array #(
      .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .COMMIT_W(COMMIT_W), .CPL_PORTS(CPL_PORTS)
   ) u_ents (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_en   (grant),
      .alloc_base (tail_q),
      .alloc_cnt  (iss_cnt),
      .alloc_kind (iss_kind),
      .cpl_vld    (cpl_vld),
      .cpl_idx    (cpl_idx),
      .cpl_err    (cpl_err),
      .ret_base   (head_q),
      .ret_cnt    (ret_cnt),
      .ent_vld    (ent_vld),
      .ent_done   (ent_done),
      .ent_err    (ent_err),
      .ent_kind   (ent_kind)
   );

   icb_commit_scan #(.DEPTH(DEPTH), .COMMIT_W(COMMIT_W)) u_scan (
      .ent_vld     (ent_vld),
      .ent_done    (ent_done),
      .ent_err     (ent_err),
      .ent_kind    (ent_kind),
      .head        (head_q),
      .ret_cnt     (ret_cnt),
      .ret_special (ret_special),
      .head_fault  (head_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
         blk_q  <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         if (grant) tail_q <= tail_q + IDX_W'(iss_cnt);
         head_q <= head_q + IDX_W'(ret_cnt);
         occ_q  <= occ_q + (grant ? OW'(iss_cnt) : OW'(0)) - OW'(ret_cnt);
         if (grant && grant_blk) blk_q <= 1'b1;
         else if (ret_special)   blk_q <= 1'b0;
         if (exc_vld) seen_q <= 1'b1;
      end
   end

   assign iss_ready = grant;
   assign iss_tail  = tail_q;
   assign cmt_cnt   = ret_cnt;
   assign cmt_head  = head_q;
   assign exc_vld   = head_fault && !seen_q;
   assign exc_idx   = head_q;
   assign occ       = occ_q;

endmodule

// File: rtl/icb_checker.sv
module icb_checker #(
   parameter int DEPTH    = 64,
   parameter int ISSUE_W  = 4,
   parameter int COMMIT_W = 4,
   localparam int NW      = $clog2(ISSUE_W + 1),
   localparam int CW      = $clog2(COMMIT_W + 1),
   localparam int OW      = $clog2(DEPTH + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NW-1:0]        iss_cnt,
   input logic [2*ISSUE_W-1:0] iss_kind,
   input logic                 iss_ready,
   input logic                 flush,
   input logic [CW-1:0]        cmt_cnt,
   input logic                 exc_vld,
   input logic [OW-1:0]        occ
);

   assert_grant_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ready |-> (int'(occ) + int'(iss_cnt) <= DEPTH));

   assert_retire_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cmt_cnt) <= int'(occ)) && (int'(cmt_cnt) <= COMMIT_W));

   assert_exc_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vld |=> !exc_vld);

   assert_exc_halts_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vld |-> cmt_cnt == '0);

   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> occ == '0);

   assert_sync_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_ready && iss_kind[1:0] == 2'b01) |-> (occ == '0 && int'(iss_cnt) == 1));

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= DEPTH);

   assert_occ_balance_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(flush)) |->
         int'(occ) == int'($past(occ)) + ($past(iss_ready) ? int'($past(iss_cnt)) : 0)
                      - int'($past(cmt_cnt)));

endmodule

bind inorder_commit_buf icb_checker #(
   .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .COMMIT_W(COMMIT_W)
) u_icb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_cnt   (iss_cnt),
   .iss_kind  (iss_kind),
   .iss_ready (iss_ready),
   .flush     (flush),
   .cmt_cnt   (cmt_cnt),
   .exc_vld   (exc_vld),
   .occ       (occ)
);

// File: tb/inorder_commit_buf_bench.sv
module inorder_commit_buf_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  iss_cnt;
   logic [7:0]  iss_kind;
   logic        iss_ready;
   logic [5:0]  iss_tail;
   logic [1:0]  cpl_vld;
   logic [11:0] cpl_idx;
   logic [1:0]  cpl_err;
   logic        flush;
   logic [2:0]  cmt_cnt;
   logic [5:0]  cmt_head;
   logic        exc_vld;
   logic [5:0]  exc_idx;
   logic [6:0]  occ;

   int n_chk = 0;
   int n_err = 0;
   int tl = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   inorder_commit_buf u_inorder_commit_buf (
      .clk(clk), .rst_n(rst_n), .iss_cnt(iss_cnt), .iss_kind(iss_kind),
      .iss_ready(iss_ready), .iss_tail(iss_tail), .cpl_vld(cpl_vld),
      .cpl_idx(cpl_idx), .cpl_err(cpl_err), .flush(flush), .cmt_cnt(cmt_cnt),
      .cmt_head(cmt_head), .exc_vld(exc_vld), .exc_idx(exc_idx), .occ(occ)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic try_issue(int n, logic [7:0] k, bit ok, string req);
      iss_cnt  = 3'(n);
      iss_kind = k;
      #1;
      check(req, "iss_ready", int'(iss_ready), int'(ok));
      if (ok) check(req, "iss_tail", int'(iss_tail), tl);
      tick();
      iss_cnt  = '0;
      iss_kind = '0;
      if (ok) tl = (tl + n) % 64;
   endtask

   task automatic cpl2(int a, bit ea, int b, bit eb, bit use_b);
      cpl_vld = {use_b, 1'b1};
      cpl_idx = {6'(b), 6'(a)};
      cpl_err = {eb, ea};
      tick();
      cpl_vld = '0;
      cpl_err = '0;
   endtask

   task automatic cpl1(int a, bit ea);
      cpl2(a, ea, 0, 1'b0, 1'b0);
   endtask

   task automatic complete_span(int start, int n);
      for (int j = 0; j < n; j += 2) begin
         if (j + 1 < n) cpl2((start + j) % 64, 1'b0, (start + j + 1) % 64, 1'b0, 1'b1);
         else           cpl1((start + j) % 64, 1'b0);
      end
   endtask

   task automatic drain(string req);
      for (int g = 0; g < 300 && occ != '0; g++) tick();
      check(req, "occ after drain", int'(occ), 0);
   endtask

   // R1
   task automatic t_reset();
      check("R1", "occ", int'(occ), 0);
      check("R1", "cmt_cnt", int'(cmt_cnt), 0);
      check("R1", "exc_vld", int'(exc_vld), 0);
      check("R1", "iss_tail", int'(iss_tail), 0);
      iss_cnt = 3'd4;
      #1;
      check("R1", "iss_ready for four", int'(iss_ready), 1);
      iss_cnt = '0;
   endtask

   // R2 R4 R5 R12
   task automatic t_order();
      try_issue(4, 8'h00, 1'b1, "R2");
      try_issue(3, 8'h00, 1'b1, "R2");
      check("R2", "occ after 7", int'(occ), 7);
      cpl2(1, 1'b0, 2, 1'b0, 1'b1);
      check("R5", "younger held", int'(cmt_cnt), 0);
      cpl1(0, 1'b0);
      check("R4", "retire run of 3", int'(cmt_cnt), 3);
      check("R4", "cmt_head", int'(cmt_head), 0);
      tick();
      check("R4", "occ after run", int'(occ), 4);
      cpl2(3, 1'b0, 4, 1'b0, 1'b1);
      check("R4", "retire 3,4", int'(cmt_cnt), 2);
      cpl2(5, 1'b0, 6, 1'b0, 1'b1);
      check("R4", "retire 5,6", int'(cmt_cnt), 2);
      tick();
      check("R4", "occ empty", int'(occ), 0);
      try_issue(4, 8'h00, 1'b1, "R2");
      try_issue(2, 8'h00, 1'b1, "R2");
      cpl2(8, 1'b0, 9, 1'b0, 1'b1);
      cpl2(10, 1'b0, 11, 1'b0, 1'b1);
      cpl1(12, 1'b0);
      check("R5", "head 7 pending", int'(cmt_cnt), 0);
      cpl1(7, 1'b0);
      check("R4", "retire limit 4", int'(cmt_cnt), 4);
      check("R4", "cmt_head 7", int'(cmt_head), 7);
      iss_cnt = 3'd2;
      iss_kind = '0;
      #1;
      check("R12", "grant with retire", int'(iss_ready), 1);
      check("R12", "iss_tail", int'(iss_tail), 13);
      tick();
      iss_cnt = '0;
      tl = 15;
      check("R12", "occ 6+2-4", int'(occ), 4);
      check("R4", "retire 11,12", int'(cmt_cnt), 2);
      tick();
      check("R4", "occ 2", int'(occ), 2);
      cpl2(13, 1'b0, 14, 1'b0, 1'b1);
      check("R4", "retire 13,14", int'(cmt_cnt), 2);
      tick();
      check("R4", "occ 0", int'(occ), 0);
   endtask

   // R6 R7
   task automatic t_error_flush();
      try_issue(2, 8'h00, 1'b1, "R6");
      cpl2(15, 1'b1, 16, 1'b0, 1'b1);
      check("R6", "exc_vld", int'(exc_vld), 1);
      check("R6", "exc_idx", int'(exc_idx), 15);
      check("R6", "retire halted", int'(cmt_cnt), 0);
      tick();
      check("R6", "exc pulse ends", int'(exc_vld), 0);
      check("R6", "still halted", int'(cmt_cnt), 0);
      check("R6", "occ kept", int'(occ), 2);
      flush = 1'b1;
      iss_cnt = 3'd1;
      #1;
      check("R7", "issue refused in flush", int'(iss_ready), 0);
      tick();
      flush = 1'b0;
      iss_cnt = '0;
      check("R7", "occ after flush", int'(occ), 0);
      check("R7", "tail restart", int'(iss_tail), 0);
      check("R7", "head restart", int'(cmt_head), 0);
      check("R7", "exc cleared", int'(exc_vld), 0);
      tl = 0;
   endtask

   // R3 R10
   task automatic t_capacity();
      for (int g = 0; g < 15; g++) try_issue(4, 8'h00, 1'b1, "R10");
      try_issue(3, 8'h00, 1'b1, "R10");
      check("R10", "occ 63", int'(occ), 63);
      try_issue(2, 8'h00, 1'b0, "R3");
      check("R3", "occ unchanged", int'(occ), 63);
      try_issue(1, 8'h00, 1'b1, "R10");
      check("R10", "occ full", int'(occ), 64);
      try_issue(1, 8'h00, 1'b0, "R10");
      complete_span(0, 64);
      drain("R10");
      for (int g = 0; g < 15; g++) try_issue(4, 8'h00, 1'b1, "R10");
      try_issue(2, 8'h00, 1'b1, "R10");
      complete_span(0, 62);
      drain("R10");
      try_issue(4, 8'h00, 1'b1, "R10");
      cpl2(0, 1'b0, 1, 1'b0, 1'b1);
      check("R5", "wrapped younger held", int'(cmt_cnt), 0);
      cpl2(62, 1'b0, 63, 1'b0, 1'b1);
      check("R10", "retire across wrap", int'(cmt_cnt), 4);
      tick();
      check("R10", "occ 0 after wrap", int'(occ), 0);
      check("R10", "head wrapped", int'(cmt_head), 2);
   endtask

   // R8
   task automatic t_sync();
      try_issue(2, 8'b0000_0001, 1'b0, "R8");
      try_issue(1, 8'h00, 1'b1, "R8");
      try_issue(1, 8'b0000_0001, 1'b0, "R8");
      cpl1(2, 1'b0);
      drain("R8");
      try_issue(1, 8'b0000_0001, 1'b1, "R8");
      try_issue(1, 8'h00, 1'b0, "R8");
      cpl1(3, 1'b0);
      check("R8", "sync retires", int'(cmt_cnt), 1);
      tick();
      try_issue(1, 8'h00, 1'b1, "R8");
      cpl1(4, 1'b0);
      drain("R8");
   endtask

   // R9
   task automatic t_stall();
      try_issue(2, 8'h00, 1'b1, "R9");
      try_issue(2, 8'b0000_0010, 1'b0, "R9");
      try_issue(2, 8'b0000_1000, 1'b1, "R9");
      try_issue(1, 8'h00, 1'b0, "R9");
      cpl2(5, 1'b0, 6, 1'b0, 1'b1);
      cpl2(7, 1'b0, 8, 1'b0, 1'b1);
      drain("R9");
      try_issue(1, 8'h00, 1'b1, "R9");
      cpl1(9, 1'b0);
      drain("R9");
   endtask

   // R11
   task automatic t_misc();
      try_issue(1, 8'b0000_0011, 1'b0, "R11");
      cpl1(10, 1'b0);
      try_issue(1, 8'h00, 1'b1, "R11");
      tick();
      tick();
      check("R11", "stale completion ignored", int'(cmt_cnt), 0);
      check("R11", "entry still held", int'(occ), 1);
      cpl1(10, 1'b0);
      drain("R11");
   endtask

   initial begin
      rst_n = 1'b0;
      iss_cnt = '0;
      iss_kind = '0;
      cpl_vld = '0;
      cpl_idx = '0;
      cpl_err = '0;
      flush = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_order();
      t_error_flush();
      t_capacity();
      t_sync();
      t_stall();
      t_misc();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule